// File: doc/BRIEF.md
# Sponge Hash Message Block Sequencer

This controller walks a sponge-construction hash engine through a message made of one or more blocks. Software or an upstream framer pulses a start input to arm it. The controller then waits for a valid block. Each block arrives with a tag that says whether it opens a multi-block message, is the whole message on its own, sits in the middle, or closes the message.

For each accepted block, the sequencer issues a single-cycle trigger to the absorb-and-permute engine. It shows the block's kind on a small code output and holds a busy flag until the engine reports that its pass has ended. Blocks that open, continue or make up a whole message return the controller to its waiting point for the next block. A closing block leads to a finished indication. The finished indication lasts until the next start, and that start puts the controller back to rest.

State storage can be built as a dense binary register or as a one-hot register. The choice is a parameter. The permutation datapath and the padding logic sit outside this block.

Top module: `hash_block_sequencer`

## Requirements
- R1: While rst_n is low at a rising clock edge, the controller returns to rest, and after that edge go_pass, busy and finished are 0 and kind is 0.
- R2: At rest, a start of 0 keeps the controller at rest, so a valid tagged block produces no go_pass. A start of 1 arms it to accept a block on a later edge.
- R3: While armed, a block is accepted only at an edge where blk_valid is 1 and at least one tag flag is set. Tag flags without blk_valid cause no trigger.
- R4: The kind output of an accepted block is coded 0 for an opening block (tag_open), 1 for a whole-message block (tag_solo), 2 for a middle block (tag_mid) and 3 for a closing block (tag_close).
- R5: When several tag flags are set together, the kind is chosen with priority solo over open, open over close, and close over mid.
- R6: go_pass is high for exactly the first cycle after a block is accepted, and only in that cycle.
- R7: busy rises together with go_pass and stays high until the rising edge at which pass_done is 1. While busy is high, kind does not change.
- R8: After pass_done ends an opening, whole-message or middle block, busy and finished are both 0 and the controller accepts another block without a new start.
- R9: After pass_done ends a closing block, finished is 1 and busy is 0 from the next cycle on.
- R10: Once finished, the controller ignores blocks while start is 0. A start of 1 clears finished and returns it to rest, and a further start is then needed before a block is accepted.
- R11: pass_done has no effect unless a pass is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arms the controller at rest, or sends it back to rest once finished |
| blk_valid | input | 1 | A message block is presented |
| tag_open | input | 1 | Block opens a multi-block message |
| tag_solo | input | 1 | Block is the whole message |
| tag_mid | input | 1 | Block lies inside the message |
| tag_close | input | 1 | Block closes the message |
| pass_done | input | 1 | Hash engine strobe that ends the current pass |
| go_pass | output | 1 | One-cycle trigger for an absorb-and-permute pass |
| kind | output | KIND_W | Code of the block being processed |
| busy | output | 1 | A pass is in progress |
| finished | output | 1 | The closing block has been processed |

## Verification
The bench builds the block with one-hot state storage and a 3-bit kind output. Linting the default parameters covers the binary storage and the 2-bit code. With the wider code, the bench can show that the upper code bit stays 0. One-hot storage keeps the decode loop under test. The stub engine answers each trigger after several cycles, which gives time to observe that busy and kind hold steady. Stray done strobes and mixed tag flags are applied both at rest and while armed.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
   typedef enum logic [2:0] {
      ST_REST  = 3'd0,
      ST_ARMED = 3'd1,
      ST_OPEN  = 3'd2,
      ST_SOLO  = 3'd3,
      ST_MID   = 3'd4,
      ST_CLOSE = 3'd5,
      ST_FIN   = 3'd6
   } hbs_state_e;

   localparam int unsigned HBS_N_STATES = 7;

   localparam logic [1:0] KIND_OPEN  = 2'd0;
   localparam logic [1:0] KIND_SOLO  = 2'd1;
   localparam logic [1:0] KIND_MID   = 2'd2;
   localparam logic [1:0] KIND_CLOSE = 2'd3;

   function automatic logic hbs_is_pass(input hbs_state_e s);
      return (s == ST_OPEN) || (s == ST_SOLO) || (s == ST_MID) || (s == ST_CLOSE);
   endfunction
endpackage

// File: rtl/hbs_tag_pick.sv
module hbs_tag_pick
   import hbs_pkg::*;
#(
   parameter int unsigned KIND_W = 2
) (
   input  logic              blk_valid,
   input  logic              tag_open,
   input  logic              tag_solo,
   input  logic              tag_mid,
   input  logic              tag_close,
   output logic              hit,
   output logic [KIND_W-1:0] kind_sel,
   output hbs_state_e        st_sel
);
   if (KIND_W < 2) begin : g_kind_w_bad
      $error("hbs_tag_pick: KIND_W must be at least 2");
   end

   always_comb begin
      hit      = 1'b0;
      kind_sel = '0;
      st_sel   = ST_ARMED;
      if (blk_valid) begin
         if (tag_solo) begin
            hit      = 1'b1;
            kind_sel = KIND_W'(KIND_SOLO);
            st_sel   = ST_SOLO;
         end else if (tag_open) begin
            hit      = 1'b1;
            kind_sel = KIND_W'(KIND_OPEN);
            st_sel   = ST_OPEN;
         end else if (tag_close) begin
            hit      = 1'b1;
            kind_sel = KIND_W'(KIND_CLOSE);
            st_sel   = ST_CLOSE;
         end else if (tag_mid) begin
            hit      = 1'b1;
            kind_sel = KIND_W'(KIND_MID);
            st_sel   = ST_MID;
         end
      end
   end
endmodule

// File: rtl/hbs_state_store.sv
module hbs_state_store
   import hbs_pkg::*;
#(
   parameter bit ONEHOT = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  hbs_state_e st_nxt,
   output hbs_state_e st_cur
);
   localparam int unsigned N = HBS_N_STATES;

   if (ONEHOT) begin : g_onehot
      logic [N-1:0] oh_q;

      always_ff @(posedge clk) begin
         if (!rst_n) oh_q <= N'(1) << ST_REST;
         else        oh_q <= N'(1) << st_nxt;
      end

      always_comb begin
         st_cur = ST_REST;
         for (int i = 0; i < int'(N); i++) begin
            if (oh_q[i]) st_cur = hbs_state_e'(3'(i));
         end
      end
   end else begin : g_binary
      hbs_state_e bin_q;

      always_ff @(posedge clk) begin
         if (!rst_n) bin_q <= ST_REST;
         else        bin_q <= st_nxt;
      end

      assign st_cur = bin_q;
   end
endmodule

// File: rtl/hbs_out_reg.sv
module hbs_out_reg
   import hbs_pkg::*;
#(
   parameter int unsigned KIND_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [KIND_W-1:0] kind_sel,
   input  hbs_state_e        st_nxt,
   output logic              go_pass,
   output logic [KIND_W-1:0] kind,
   output logic              busy,
   output logic              finished
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go_pass  <= 1'b0;
         kind     <= '0;
         busy     <= 1'b0;
         finished <= 1'b0;
      end else begin
         go_pass  <= accept;
         if (accept) kind <= kind_sel;
         busy     <= hbs_is_pass(st_nxt);
         finished <= (st_nxt == ST_FIN);
      end
   end
endmodule

// File: rtl/hash_block_sequencer.sv
module hash_block_sequencer
   import hbs_pkg::*;
#(
   parameter int unsigned KIND_W = 2,
   parameter bit          ONEHOT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              blk_valid,
   input  logic              tag_open,
   input  logic              tag_solo,
   input  logic              tag_mid,
   input  logic              tag_close,
   input  logic              pass_done,
   output logic              go_pass,
   output logic [KIND_W-1:0] kind,
   output logic              busy,
   output logic              finished
);
   if (KIND_W < 2 || KIND_W > 8) begin : g_kind_range_bad
      $error("hash_block_sequencer: KIND_W must lie in 2..8");
   end

   hbs_state_e        st_cur;
   hbs_state_e        st_nxt;
   hbs_state_e        st_sel;
   logic              hit;
   logic              accept;
   logic [KIND_W-1:0] kind_sel;

   hbs_tag_pick #(.KIND_W(KIND_W)) u_pick (
      .blk_valid (blk_valid),
      .tag_open  (tag_open),
      .tag_solo  (tag_solo),
      .tag_mid   (tag_mid),
      .tag_close (tag_close),
      .hit       (hit),
      .kind_sel  (kind_sel),
      .st_sel    (st_sel)
   );

   always_comb begin
      st_nxt = st_cur;
      unique case (st_cur)
         ST_REST:  if (start) st_nxt = ST_ARMED;
         ST_ARMED: if (hit) st_nxt = st_sel;
         ST_OPEN, ST_SOLO, ST_MID:
                   if (pass_done) st_nxt = ST_ARMED;
         ST_CLOSE: if (pass_done) st_nxt = ST_FIN;
         ST_FIN:   if (start) st_nxt = ST_REST;
         default:  st_nxt = ST_REST;
      endcase
   end

   assign accept = (st_cur == ST_ARMED) && hit;

   hbs_state_store #(.ONEHOT(ONEHOT)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .st_nxt (st_nxt),
      .st_cur (st_cur)
   );

   hbs_out_reg #(.KIND_W(KIND_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .kind_sel (kind_sel),
      .st_nxt   (st_nxt),
      .go_pass  (go_pass),
      .kind     (kind),
      .busy     (busy),
      .finished (finished)
   );
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker #(
   parameter int unsigned KIND_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pass_done,
   input logic              go_pass,
   input logic [KIND_W-1:0] kind,
   input logic              busy,
   input logic              finished
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!go_pass && !busy && !finished && kind == '0));

   // R6
   go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_pass |=> !go_pass);

   // R6
   go_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go_pass |-> busy);

   // R7
   busy_rise_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> go_pass);

   // R7
   kind_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !go_pass) |-> $stable(kind));

   // R7
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pass_done) |=> busy);

   // R8
   return_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pass_done && kind != KIND_W'(3)) |=> (!busy && !finished));

   // R9
   close_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && pass_done && kind == KIND_W'(3)) |=> (finished && !busy));

   // R9
   busy_fin_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && finished));
endmodule

bind hash_block_sequencer hbs_checker #(.KIND_W(KIND_W)) u_hbs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pass_done (pass_done),
   .go_pass   (go_pass),
   .kind      (kind),
   .busy      (busy),
   .finished  (finished)
);

// File: tb/hash_block_sequencer_test.sv
module hash_block_sequencer_test;
   localparam int unsigned KW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          blk_valid = 1'b0;
   logic          tag_open = 1'b0;
   logic          tag_solo = 1'b0;
   logic          tag_mid = 1'b0;
   logic          tag_close = 1'b0;
   logic          pass_done = 1'b0;
   logic          go_pass;
   logic [KW-1:0] kind;
   logic          busy;
   logic          finished;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   hash_block_sequencer #(.KIND_W(KW), .ONEHOT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .blk_valid(blk_valid),
      .tag_open(tag_open), .tag_solo(tag_solo), .tag_mid(tag_mid),
      .tag_close(tag_close), .pass_done(pass_done), .go_pass(go_pass),
      .kind(kind), .busy(busy), .finished(finished)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_tags(input logic v, input logic o, input logic s,
                           input logic m, input logic c);
      blk_valid = v; tag_open = o; tag_solo = s; tag_mid = m; tag_close = c;
   endtask

   task automatic pulse_start();
      start = 1'b1;
      tick();
      start = 1'b0;
   endtask

   // Present a block for one edge, check the trigger and kind, then answer as the engine stub.
   task automatic run_block(input string req, input logic o, input logic s,
                            input logic m, input logic c, input int exp_kind,
                            input int lat);
      set_tags(1'b1, o, s, m, c);
      tick();
      set_tags(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk({req, " go_pass on accept (R6)"}, int'(go_pass), 1);
      chk({req, " busy on accept (R7)"}, int'(busy), 1);
      chk({req, " kind code (R4)"}, int'(kind), exp_kind);
      for (int i = 0; i < lat; i++) begin
         tick();
         chk({req, " go_pass single cycle (R6)"}, int'(go_pass), 0);
         chk({req, " busy held (R7)"}, int'(busy), 1);
         chk({req, " kind held (R7)"}, int'(kind), exp_kind);
      end
      pass_done = 1'b1;
      tick();
      pass_done = 1'b0;
      chk({req, " busy cleared (R7)"}, int'(busy), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tick();
      tick();
      chk("R1 go_pass", int'(go_pass), 0);
      chk("R1 busy", int'(busy), 0);
      chk("R1 finished", int'(finished), 0);
      chk("R1 kind", int'(kind), 0);
      rst_n = 1'b1;
   endtask

   task automatic t_rest_ignores();
      set_tags(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
      pass_done = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R2 no trigger at rest", int'(go_pass), 0);
         chk("R11 no busy at rest", int'(busy), 0);
         chk("R2 not finished at rest", int'(finished), 0);
      end
      set_tags(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      pass_done = 1'b0;
   endtask

   task automatic t_multi_block();
      pulse_start();
      set_tags(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < 2; i++) begin
         tick();
         chk("R3 tags without valid", int'(go_pass), 0);
         chk("R3 tags without valid busy", int'(busy), 0);
      end
      set_tags(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      tick();
      chk("R3 valid without tags", int'(go_pass), 0);
      set_tags(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      pass_done = 1'b1;
      tick();
      pass_done = 1'b0;
      chk("R11 stray done while armed", int'(busy), 0);
      chk("R11 stray done no finish", int'(finished), 0);
      run_block("R4 open", 1'b1, 1'b0, 1'b0, 1'b0, 0, 3);
      chk("R8 open returns armed", int'(finished), 0);
      run_block("R4 mid", 1'b0, 1'b0, 1'b1, 1'b0, 2, 2);
      chk("R8 mid returns armed", int'(finished), 0);
      run_block("R4 mid again", 1'b0, 1'b0, 1'b1, 1'b0, 2, 0);
      run_block("R4 close", 1'b0, 1'b0, 1'b0, 1'b1, 3, 4);
      chk("R9 finished after close", int'(finished), 1);
      tick();
      chk("R9 finished holds", int'(finished), 1);
      chk("R9 busy low when finished", int'(busy), 0);
   endtask

   task automatic t_finish_hold();
      set_tags(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
      pass_done = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R10 finish ignores blocks", int'(go_pass), 0);
         chk("R10 finish holds", int'(finished), 1);
      end
      set_tags(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      pass_done = 1'b0;
      pulse_start();
      chk("R10 start clears finished", int'(finished), 0);
      set_tags(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
      tick();
      set_tags(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
      chk("R10 rest needs another start", int'(go_pass), 0);
      chk("R10 rest not busy", int'(busy), 0);
   endtask

   task automatic t_solo();
      pulse_start();
      run_block("R4 solo", 1'b0, 1'b1, 1'b0, 1'b0, 1, 3);
      chk("R8 solo returns armed", int'(finished), 0);
      run_block("R8 block after solo", 1'b0, 1'b0, 1'b0, 1'b1, 3, 1);
      chk("R9 finished after close", int'(finished), 1);
      pulse_start();
      chk("R10 back to rest", int'(finished), 0);
   endtask

   task automatic t_priority();
      pulse_start();
      run_block("R5 all tags pick solo", 1'b1, 1'b1, 1'b1, 1'b1, 1, 1);
      run_block("R5 open over close and mid", 1'b1, 1'b0, 1'b1, 1'b1, 0, 1);
      run_block("R5 close over mid", 1'b0, 1'b0, 1'b1, 1'b1, 3, 2);
      chk("R9 finished after close", int'(finished), 1);
      pulse_start();
   endtask

   initial begin
      t_reset();
      t_rest_ignores();
      t_multi_block();
      t_finish_hold();
      t_solo();
      t_priority();
      t_reset();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(4 * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule